// File: doc/BRIEF.md
# Dual-Port Shared RAM with Write Lockout and Mailbox Interrupts

This block is a synchronous memory shared by two agents, called A and B, that run from one common clock. Each agent has its own complete port: chip select, write enable, address, write data and registered read data. Both ports may read or write in the same cycle, at different addresses or at the same one.

Only one combination needs a rule: both ports writing the same word in the same cycle. Port A has fixed priority in that case. Port B's write is dropped, and a combinational busy flag tells agent B in the same cycle that its write did not land. Every other combination proceeds without a stall. A read that meets a write from the other port at the same address returns the contents from before the write.

The two highest addresses double as mailboxes. When A writes the top word, an interrupt is raised toward B. B clears it by reading that word. The word just below the top works the same way in the other direction. The interrupt flags are cleared by a synchronous active-low reset. The storage contents are not reset.

Top module: `dpr_shared_ram`

## Requirements
- R1: Writes from both ports to different addresses in the same cycle both land. A later read from either port returns each written value.
- R2: A read is performed when a port has cs=1 and we=0. Its data appears on that port's rdata one clock after the address is presented. rdata keeps its value on any cycle with no read at that port (cs=0, or a write).
- R3: When both ports write the same address in the same cycle, A's data is stored, B's data is discarded, and b_busy is 1 during that cycle.
- R4: b_busy is 0 in every cycle that is not a same-address double write. This covers read with read, read with write at the same address, writes to different addresses, and idle ports.
- R5: When one port reads an address in the same cycle that the other port writes it, the read returns the old contents.
- R6: A write by A that lands at address 2^ADDR_W-1 sets b_irq from the next clock. A read by B of that address clears b_irq at the next clock. If both happen in one cycle, b_irq ends up set.
- R7: A write by B that lands at address 2^ADDR_W-2 sets a_irq from the next clock. A read by A of that address clears a_irq. If both happen in one cycle, a_irq ends up set. A B write discarded by R3 sets nothing.
- R8: A port writing its own incoming mailbox raises no interrupt: B writing 2^ADDR_W-1 leaves b_irq unchanged, and A writing 2^ADDR_W-2 leaves a_irq unchanged.
- R9: With rst_n=0 at a clock edge, a_irq, b_irq, a_rdata and b_rdata become 0. Stored words survive the reset.
- R10: With cs=0, a port neither writes nor reads, whatever its we, address and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset of interrupt flags and read registers |
| a_cs | input | 1 | Port A select |
| a_we | input | 1 | Port A write enable (1 write, 0 read) |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| a_irq | output | 1 | Mail waiting for A (B wrote 2^ADDR_W-2) |
| b_cs | input | 1 | Port B select |
| b_we | input | 1 | Port B write enable (1 write, 0 read) |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |
| b_busy | output | 1 | Combinational: B's write this cycle is locked out |
| b_irq | output | 1 | Mail waiting for B (A wrote 2^ADDR_W-1) |

## Verification
Port pairs are driven in every combination that matters. Same-address double writes are checked against double writes at different addresses, which shows whether the lockout is keyed to the address and not just to two writes. Same-address read/write pairs in both directions separate read-before-write behaviour from write-through behaviour. Mailbox sequences then set and clear each flag in turn: a set and a clear in the same cycle, a locked-out write to a mailbox, and a port writing its own incoming mailbox. These separate the correct event from every nearby one. A reset in the middle of the run shows that the flags clear while the stored words are kept.

// File: rtl/dpr_pkg.sv
// Package shared by the dual-port RAM modules.
// Holds the mailbox slot numbering so that every module derives the same
// addresses from ADDR_W. Assumes the address width is at least 2.
package dpr_pkg;

    // Mailbox slots, counted down from the top of the address space.
    typedef enum int unsigned {
        SLOT_TO_B = 0,   // written by A, read by B
        SLOT_TO_A = 1    // written by B, read by A
    } mbox_slot_e;

    // Word address of a mailbox slot for an array of 2**aw words.
    function automatic int unsigned mbox_addr(int unsigned aw, mbox_slot_e slot);
        return (32'd1 << aw) - 32'd1 - int'(slot);
    endfunction

endpackage

// File: rtl/dpr_clash.sv
// Port request decoder and collision resolver.
// Turns each port's chip select and write enable into read and write
// strobes. When both ports write the same word, it withholds B's write and
// raises busy. Assumes one shared clock. Purely combinational.
module dpr_clash #(
    parameter int ADDR_W = 4
) (
    input  logic              a_cs,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_cs,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              a_wr,
    output logic              a_rd,
    output logic              b_wr,
    output logic              b_rd,
    output logic              b_busy
);

    logic a_wants_wr;
    logic b_wants_wr;
    logic same_word;

    // Decode the raw requests of each port.
    always_comb begin
        a_wants_wr = a_cs & a_we;
        b_wants_wr = b_cs & b_we;
        a_rd       = a_cs & ~a_we;
        b_rd       = b_cs & ~b_we;
    end

    // Fixed priority: A keeps the word, B is locked out on a clash.
    always_comb begin
        same_word = (a_addr == b_addr);
        b_busy    = a_wants_wr & b_wants_wr & same_word;
        a_wr      = a_wants_wr;
        b_wr      = b_wants_wr & ~b_busy;
    end

endmodule

// File: rtl/dpr_array.sv
// Storage array with two write ports and two registered read ports.
// A read samples the word before any write of the same edge (read before
// write). Assumes the strobes never ask for two writes to one word; the
// collision resolver upstream guarantees this. Contents are not reset.
module dpr_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_a,
    input  logic              rd_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] wdata_a,
    input  logic              wr_b,
    input  logic              rd_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] wdata_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Commit the writes of both ports at the clock edge.
    always_ff @(posedge clk) begin
        if (wr_a) mem[addr_a] <= wdata_a;
        if (wr_b) mem[addr_b] <= wdata_b;
    end

    // Registered read ports; each holds its value when its port does not read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_a <= '0;
            rdata_b <= '0;
        end else begin
            if (rd_a) rdata_a <= mem[addr_a];
            if (rd_b) rdata_b <= mem[addr_b];
        end
    end

    AST_NO_DOUBLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a && wr_b) |-> (addr_a != addr_b)); // R3

    AST_RDATA_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_a |=> $stable(rdata_a)); // R2

    AST_RDATA_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_b |=> $stable(rdata_b)); // R2

endmodule

// File: rtl/dpr_mailbox.sv
// Mailbox interrupt flags for both directions.
// Watches the landed writes and the reads at the two top addresses. A
// landed write sets the receiver's flag, and the receiver's read clears it.
// A set takes priority over a clear in the same cycle. Synchronous
// active-low reset.
module dpr_mailbox #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr,
    input  logic              a_rd,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_wr,
    input  logic              b_rd,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              a_irq,
    output logic              b_irq
);

    localparam logic [ADDR_W-1:0] MB_TO_B =
        ADDR_W'(dpr_pkg::mbox_addr(ADDR_W, dpr_pkg::SLOT_TO_B));
    localparam logic [ADDR_W-1:0] MB_TO_A =
        ADDR_W'(dpr_pkg::mbox_addr(ADDR_W, dpr_pkg::SLOT_TO_A));

    logic set_b, clr_b, set_a, clr_a;

    // Detect post and pickup events for each direction.
    always_comb begin
        set_b = a_wr & (a_addr == MB_TO_B);
        clr_b = b_rd & (b_addr == MB_TO_B);
        set_a = b_wr & (b_addr == MB_TO_A);
        clr_a = a_rd & (a_addr == MB_TO_A);
    end

    // Hold the flags; a set outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_irq <= 1'b0;
            b_irq <= 1'b0;
        end else begin
            if (set_b)      b_irq <= 1'b1;
            else if (clr_b) b_irq <= 1'b0;
            if (set_a)      a_irq <= 1'b1;
            else if (clr_a) a_irq <= 1'b0;
        end
    end

    AST_IRQ_B_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && a_addr == MB_TO_B) |=> b_irq); // R6

    AST_IRQ_B_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (b_rd && b_addr == MB_TO_B && !(a_wr && a_addr == MB_TO_B)) |=> !b_irq); // R6

    AST_IRQ_A_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (b_wr && b_addr == MB_TO_A) |=> a_irq); // R7

    AST_IRQ_A_OWN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_irq && !(b_wr && b_addr == MB_TO_A)) |=> !a_irq); // R8

endmodule

// File: rtl/dpr_shared_ram.sv
// Dual-port shared RAM, top level.
// Two independent ports on one clock share one array. On a same-address
// double write, A wins and B sees busy. The two top words act as mailboxes
// that interrupt the other side. Read data is registered; busy is
// combinational.
module dpr_shared_ram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_cs,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq,
    input  logic              b_cs,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_busy,
    output logic              b_irq
);

    logic a_wr, a_rd, b_wr, b_rd;

    dpr_clash #(.ADDR_W(ADDR_W)) u_clash (
        .a_cs   (a_cs),
        .a_we   (a_we),
        .a_addr (a_addr),
        .b_cs   (b_cs),
        .b_we   (b_we),
        .b_addr (b_addr),
        .a_wr   (a_wr),
        .a_rd   (a_rd),
        .b_wr   (b_wr),
        .b_rd   (b_rd),
        .b_busy (b_busy)
    );

    dpr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_a    (a_wr),
        .rd_a    (a_rd),
        .addr_a  (a_addr),
        .wdata_a (a_wdata),
        .wr_b    (b_wr),
        .rd_b    (b_rd),
        .addr_b  (b_addr),
        .wdata_b (b_wdata),
        .rdata_a (a_rdata),
        .rdata_b (b_rdata)
    );

    dpr_mailbox #(.ADDR_W(ADDR_W)) u_mbox (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_wr   (a_wr),
        .a_rd   (a_rd),
        .a_addr (a_addr),
        .b_wr   (b_wr),
        .b_rd   (b_rd),
        .b_addr (b_addr),
        .a_irq  (a_irq),
        .b_irq  (b_irq)
    );

    AST_BUSY_NEEDS_TWO_WRITERS: assert property (@(posedge clk) disable iff (!rst_n)
        b_busy |-> (a_cs && a_we && b_cs && b_we)); // R4

endmodule

// File: tb/test_dpr_shared_ram.sv
// Self-checking bench: a vector table walked against a behavioural model,
// then directed reset and hold cases.
module test_dpr_shared_ram;

    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] TOP  = AW'(DEPTH - 1);
    localparam logic [AW-1:0] TOP1 = AW'(DEPTH - 2);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          a_cs, a_we, b_cs, b_we;
    logic [AW-1:0] a_addr, b_addr;
    logic [DW-1:0] a_wdata, b_wdata;
    logic [DW-1:0] a_rdata, b_rdata;
    logic          a_irq, b_irq, b_busy;

    int n_checks = 0;
    int n_fail   = 0;

    // Behavioural model state.
    logic [DW-1:0] m_mem [DEPTH];
    logic [DW-1:0] m_ra, m_rb;
    logic          m_ia, m_ib;

    always #10 clk = ~clk;

    dpr_shared_ram #(.ADDR_W(AW), .DATA_W(DW)) i_dpr_shared_ram (
        .clk(clk), .rst_n(rst_n),
        .a_cs(a_cs), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_cs(b_cs), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_busy(b_busy), .b_irq(b_irq)
    );

    // Vector: {a_cs,a_we,a_addr,a_wdata, b_cs,b_we,b_addr,b_wdata}
    localparam int NV = 20;
    localparam logic [27:0] VEC [NV] = '{
        {1'b1,1'b1,4'd3,8'hA5,  1'b1,1'b1,4'd3,8'h5A},   // 0  clash at 3
        {1'b1,1'b0,4'd3,8'h00,  1'b1,1'b0,4'd3,8'h00},   // 1  both read 3
        {1'b1,1'b1,4'd4,8'h11,  1'b1,1'b1,4'd5,8'h22},   // 2  writes, different words
        {1'b1,1'b0,4'd4,8'h00,  1'b1,1'b0,4'd5,8'h00},   // 3  read them back
        {1'b1,1'b1,4'd6,8'h33,  1'b1,1'b0,4'd6,8'h00},   // 4  A writes, B reads 6
        {1'b1,1'b0,4'd6,8'h00,  1'b1,1'b1,4'd6,8'h44},   // 5  A reads, B writes 6
        {1'b1,1'b0,4'd6,8'h00,  1'b1,1'b0,4'd6,8'h00},   // 6  both read 6
        {1'b0,1'b1,4'd7,8'hFF,  1'b1,1'b0,4'd7,8'h00},   // 7  A deselected write
        {1'b1,1'b1,4'd15,8'h77, 1'b0,1'b0,4'd0,8'h00},   // 8  A posts to B
        {1'b0,1'b0,4'd0,8'h00,  1'b1,1'b0,4'd15,8'h00},  // 9  B picks up
        {1'b0,1'b0,4'd0,8'h00,  1'b1,1'b1,4'd15,8'h88},  // 10 B writes own inbox
        {1'b1,1'b1,4'd14,8'h99, 1'b0,1'b0,4'd0,8'h00},   // 11 A writes own inbox
        {1'b0,1'b0,4'd0,8'h00,  1'b1,1'b1,4'd14,8'h66},  // 12 B posts to A
        {1'b1,1'b0,4'd14,8'h00, 1'b0,1'b0,4'd0,8'h00},   // 13 A picks up
        {1'b1,1'b1,4'd15,8'h12, 1'b1,1'b0,4'd15,8'h00},  // 14 set and clear together
        {1'b0,1'b0,4'd0,8'h00,  1'b1,1'b0,4'd15,8'h00},  // 15 B picks up
        {1'b1,1'b1,4'd15,8'h34, 1'b1,1'b1,4'd15,8'h56},  // 16 clash at B's inbox
        {1'b0,1'b0,4'd0,8'h00,  1'b1,1'b0,4'd15,8'h00},  // 17 B picks up
        {1'b1,1'b1,4'd14,8'h9A, 1'b1,1'b1,4'd14,8'hBC},  // 18 clash at A's inbox
        {1'b1,1'b0,4'd14,8'h00, 1'b0,1'b0,4'd0,8'h00}    // 19 A reads, no irq
    };

    // Requirement named by each table row.
    function automatic string row_tag(int i);
        case (i)
            0, 1, 16, 18:  return "R3";
            2, 3:          return "R1";
            4, 5, 6:       return "R5";
            7:             return "R10";
            8, 9, 14, 15, 17: return "R6";
            10, 11:        return "R8";
            default:       return "R7";
        endcase
    endfunction

    task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Apply one vector for one cycle and compare against the model.
    task automatic step(logic [27:0] v, string req);
        logic          ac, aw, bc, bw, ebusy, nia, nib;
        logic [AW-1:0] aa, ba;
        logic [DW-1:0] ad, bd, nra, nrb;
        {ac, aw, aa, ad, bc, bw, ba, bd} = v;
        @(negedge clk);
        a_cs = ac; a_we = aw; a_addr = aa; a_wdata = ad;
        b_cs = bc; b_we = bw; b_addr = ba; b_wdata = bd;
        ebusy = ac && aw && bc && bw && (aa == ba);
        nra = (ac && !aw) ? m_mem[aa] : m_ra;
        nrb = (bc && !bw) ? m_mem[ba] : m_rb;
        nib = (ac && aw && aa == TOP) ? 1'b1 : ((bc && !bw && ba == TOP) ? 1'b0 : m_ib);
        nia = (bc && bw && !ebusy && ba == TOP1) ? 1'b1 : ((ac && !aw && aa == TOP1) ? 1'b0 : m_ia);
        #5;
        check(ebusy ? "R3" : "R4", "b_busy", {7'd0, b_busy}, {7'd0, ebusy});
        check("R2", "a_rdata before edge", a_rdata, m_ra);
        check("R2", "b_rdata before edge", b_rdata, m_rb);
        if (ac && aw) m_mem[aa] = ad;
        if (bc && bw && !ebusy) m_mem[ba] = bd;
        m_ra = nra; m_rb = nrb; m_ia = nia; m_ib = nib;
        @(posedge clk);
        #2;
        check(req, "a_rdata", a_rdata, m_ra);
        check(req, "b_rdata", b_rdata, m_rb);
        check(req, "a_irq", {7'd0, a_irq}, {7'd0, m_ia});
        check(req, "b_irq", {7'd0, b_irq}, {7'd0, m_ib});
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        rst_n = 1'b0;
        a_cs = 0; a_we = 0; a_addr = '0; a_wdata = '0;
        b_cs = 0; b_we = 0; b_addr = '0; b_wdata = '0;
        m_ra = '0; m_rb = '0; m_ia = 1'b0; m_ib = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        // R9: reset state.
        check("R9", "a_rdata after reset", a_rdata, 8'h00);
        check("R9", "b_rdata after reset", b_rdata, 8'h00);
        check("R9", "irqs after reset", {6'd0, a_irq, b_irq}, 8'h00);
        check("R4", "b_busy idle", {7'd0, b_busy}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // Fill the array: A writes low half, B writes high half (R1).
        for (int i = 0; i < DEPTH / 2; i++)
            step({1'b1, 1'b1, AW'(i), DW'(8'h10 + i),
                  1'b1, 1'b1, AW'(i + DEPTH / 2), DW'(8'h80 + i)}, "R1");
        // R7: B's fill write at 14 set a_irq; A clears it by reading.
        step({1'b1, 1'b0, TOP1, 8'h00, 1'b0, 1'b0, 4'd0, 8'h00}, "R7");

        // Table walk.
        for (int i = 0; i < NV; i++) step(VEC[i], row_tag(i));

        // R2: read data holds across idle and write cycles.
        step({1'b1, 1'b0, 4'd2, 8'h00, 1'b1, 1'b0, 4'd9, 8'h00}, "R2");
        step({1'b0, 1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 4'd10, 8'h5C}, "R2");
        step({1'b1, 1'b1, 4'd1, 8'hC3, 1'b0, 1'b1, 4'd1, 8'hEE}, "R10");
        step({1'b1, 1'b0, 4'd1, 8'h00, 1'b1, 1'b0, 4'd10, 8'h00}, "R10");

        // R9: mid-run reset with b_irq set; words survive.
        step({1'b1, 1'b1, TOP, 8'h3C, 1'b0, 1'b0, 4'd0, 8'h00}, "R6");
        @(negedge clk);
        rst_n = 1'b0;
        a_cs = 0; b_cs = 0;
        @(posedge clk);
        #2;
        check("R9", "b_irq cleared by reset", {7'd0, b_irq}, 8'h00);
        check("R9", "a_rdata cleared by reset", a_rdata, 8'h00);
        check("R9", "b_rdata cleared by reset", b_rdata, 8'h00);
        m_ra = '0; m_rb = '0; m_ia = 1'b0; m_ib = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step({1'b1, 1'b0, 4'd6, 8'h00, 1'b1, 1'b0, TOP, 8'h00}, "R9");

        report();
    end

endmodule